// File: doc/BRIEF.md
# Timer Output-Compare Channel with Software Forcing

This block is one compare channel that sits beside a free-running timer counter. It compares the counter value against a shadow compare register. From the result and a four-bit mode field it builds an active-high reference waveform. The pin output is that reference passed through a polarity inverter and gated by an output enable. Software can write the compare value directly, or stage it in a preload register that moves into the shadow copy on the counter's update event.

Two mode codes force the reference high or low and ignore the counter. The comparison still runs during forcing. A match still sets the sticky match flag, which drives the interrupt request, and it still emits a DMA request pulse. The channel acts only while its direction-select field reads 00 (output). With any other value the reference holds and no match is recorded.

Top module: `oc_channel`

## Requirements
- R1: With `preload_en_i` low, a `ccr_wr_i` write reaches the shadow register at the next clock edge. With `preload_en_i` high, a write goes only to the preload register, and the shadow register takes the preload value at the clock edge on which `update_i` is high.
- R2: A match event is the first cycle in which `cnt_i` equals the shadow value after a cycle in which it did not. A match event needs `dir_sel_i` == 2'b00, and `flag_o` rises at the clock edge that ends that cycle.
- R3: `flag_o` stays high until a cycle with `flag_clr_i` high. If a match event and a clear fall in the same cycle, the flag stays set.
- R4: `irq_o` equals `flag_o` AND `irq_en_i`. `dma_o` is high for exactly the one cycle after each match event, and only if `dma_en_i` was high in the event cycle.
- R5: Mode 4'b0000 and every code from 4'b0110 upward leave `ref_o` unchanged.
- R6: On a match event, mode 4'b0001 sets `ref_o` to 1, mode 4'b0010 clears it to 0, and mode 4'b0011 inverts it. Each change appears at the following clock edge.
- R7: Mode 4'b0101 drives `ref_o` to 1 and mode 4'b0100 drives it to 0 at the next clock edge, whatever the counter value.
- R8: In the forcing modes, match events still set `flag_o`, `irq_o` and `dma_o` as in R2 to R4.
- R9: When `dir_sel_i` is not 2'b00, `ref_o` holds its value in every mode and no match event occurs.
- R10: `pin_o` equals `ref_o` XOR `pol_i` while `out_en_i` is 1, and is 0 while `out_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Timer counter value |
| update_i | input | 1 | Counter update event |
| ccr_wr_i | input | 1 | Compare register write strobe |
| ccr_wdata_i | input | CNT_W | Compare write data |
| preload_en_i | input | 1 | Route writes through the preload register |
| dir_sel_i | input | 2 | Channel direction; 00 selects output |
| mode_i | input | 4 | Reference mode code |
| pol_i | input | 1 | Pin polarity; 1 inverts |
| out_en_i | input | 1 | Pin output enable |
| irq_en_i | input | 1 | Interrupt request enable |
| dma_en_i | input | 1 | DMA request enable |
| flag_clr_i | input | 1 | Software clear of the match flag |
| ref_o | output | 1 | Active-high reference waveform |
| pin_o | output | 1 | Polarity-adjusted pin level |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Interrupt request |
| dma_o | output | 1 | DMA request pulse |

## Verification
The checker tests several properties on every clock. Forced levels appear one cycle after the mode is applied. The reference holds in frozen modes and in non-output direction. The flag stays sticky until it is cleared. The pin is quiet while disabled, the interrupt is gated by its enable, and the DMA output never lasts longer than one cycle. The bench scenarios cover what needs the counter's history:
- the edge-qualified match and the toggle sequence;
- when a preload value takes effect relative to the update event;
- flag and request activity that continues while the reference is forced;
- polarity inversion across both pin levels.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [3:0] {
        OCM_FROZEN = 4'b0000,
        OCM_SET    = 4'b0001,
        OCM_CLR    = 4'b0010,
        OCM_TOGGLE = 4'b0011,
        OCM_FLOW   = 4'b0100,
        OCM_FHIGH  = 4'b0101
    } oc_mode_e;

    localparam logic [1:0] DIR_OUTPUT = 2'b00;

    typedef struct packed {
        logic ref_lvl;
        logic flag;
        logic dma;
    } oc_ref_state_t;

endpackage

// File: rtl/oc_shadow.sv
module oc_shadow #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             preload_i,
    input  logic             update_i,
    output logic [CNT_W-1:0] shadow_o
);
    typedef struct packed {
        logic [CNT_W-1:0] pre;
        logic [CNT_W-1:0] sh;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.pre = wdata_i;
        end
        if (!preload_i && wr_i) begin
            st_d.sh = wdata_i;
        end else if (preload_i && update_i) begin
            st_d.sh = st_q.pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow_o = st_q.sh;
endmodule

// File: rtl/oc_match.sv
module oc_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] shadow_i,
    input  logic             active_i,
    output logic             evt_o
);
    logic eq;
    logic eq_d, eq_q;

    always_comb begin
        eq    = (cnt_i == shadow_i);
        eq_d  = eq;
        evt_o = active_i && eq && !eq_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eq_q <= 1'b0;
        end else begin
            eq_q <= eq_d;
        end
    end
endmodule

// File: rtl/oc_ref.sv
module oc_ref
    import oc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_i,
    input  logic       active_i,
    input  logic [3:0] mode_i,
    input  logic       flag_clr_i,
    input  logic       dma_en_i,
    output logic       ref_o,
    output logic       flag_o,
    output logic       dma_o
);
    oc_ref_state_t st_d, st_q;
    oc_mode_e      mode;

    always_comb begin
        mode = oc_mode_e'(mode_i);
        st_d = st_q;
        if (active_i) begin
            unique case (mode)
                OCM_SET:    if (evt_i) st_d.ref_lvl = 1'b1;
                OCM_CLR:    if (evt_i) st_d.ref_lvl = 1'b0;
                OCM_TOGGLE: if (evt_i) st_d.ref_lvl = ~st_q.ref_lvl;
                OCM_FLOW:   st_d.ref_lvl = 1'b0;
                OCM_FHIGH:  st_d.ref_lvl = 1'b1;
                default:    st_d.ref_lvl = st_q.ref_lvl;
            endcase
        end
        if (evt_i) begin
            st_d.flag = 1'b1;
        end else if (flag_clr_i) begin
            st_d.flag = 1'b0;
        end
        st_d.dma = evt_i && dma_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_o  = st_q.ref_lvl;
    assign flag_o = st_q.flag;
    assign dma_o  = st_q.dma;
endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             update_i,
    input  logic             ccr_wr_i,
    input  logic [CNT_W-1:0] ccr_wdata_i,
    input  logic             preload_en_i,
    input  logic [1:0]       dir_sel_i,
    input  logic [3:0]       mode_i,
    input  logic             pol_i,
    input  logic             out_en_i,
    input  logic             irq_en_i,
    input  logic             dma_en_i,
    input  logic             flag_clr_i,
    output logic             ref_o,
    output logic             pin_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic             dma_o
);
    logic [CNT_W-1:0] shadow;
    logic             active;
    logic             evt;

    assign active = (dir_sel_i == DIR_OUTPUT);

    oc_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (ccr_wr_i),
        .wdata_i  (ccr_wdata_i),
        .preload_i(preload_en_i),
        .update_i (update_i),
        .shadow_o (shadow)
    );

    oc_match #(.CNT_W(CNT_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (cnt_i),
        .shadow_i(shadow),
        .active_i(active),
        .evt_o   (evt)
    );

    oc_ref u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .active_i  (active),
        .mode_i    (mode_i),
        .flag_clr_i(flag_clr_i),
        .dma_en_i  (dma_en_i),
        .ref_o     (ref_o),
        .flag_o    (flag_o),
        .dma_o     (dma_o)
    );

    always_comb begin
        pin_o = out_en_i ? (ref_o ^ pol_i) : 1'b0;
        irq_o = flag_o && irq_en_i;
    end
endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] dir_sel_i,
    input logic [3:0] mode_i,
    input logic       out_en_i,
    input logic       irq_en_i,
    input logic       flag_clr_i,
    input logic       ref_o,
    input logic       pin_o,
    input logic       flag_o,
    input logic       irq_o,
    input logic       dma_o
);
    // R7: forced levels appear on the next edge
    a_r7_force_high: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_sel_i == 2'b00 && mode_i == 4'b0101) |=> ref_o);
    a_r7_force_low: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_sel_i == 2'b00 && mode_i == 4'b0100) |=> !ref_o);
    // R5: frozen mode keeps the reference
    a_r5_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_sel_i == 2'b00 && mode_i == 4'b0000) |=> $stable(ref_o));
    // R9: non-output direction holds reference and records no match
    a_r9_input_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_sel_i != 2'b00) |=> ($stable(ref_o) && !$rose(flag_o)));
    // R3: flag is sticky
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o);
    // R10: disabled pin stays low
    a_r10_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_i |-> !pin_o);
    // R4: interrupt gated by enable, DMA request is a single-cycle pulse
    a_r4_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o);
    a_r4_dma_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dma_o |=> !dma_o);
endmodule

bind oc_channel oc_channel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_sel_i (dir_sel_i),
    .mode_i    (mode_i),
    .out_en_i  (out_en_i),
    .irq_en_i  (irq_en_i),
    .flag_clr_i(flag_clr_i),
    .ref_o     (ref_o),
    .pin_o     (pin_o),
    .flag_o    (flag_o),
    .irq_o     (irq_o),
    .dma_o     (dma_o)
);

// File: tb/oc_channel_bench.sv
`timescale 1ns/1ps
module oc_channel_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_i = '0;
    logic         update_i = 1'b0;
    logic         ccr_wr_i = 1'b0;
    logic [W-1:0] ccr_wdata_i = '0;
    logic         preload_en_i = 1'b0;
    logic [1:0]   dir_sel_i = 2'b00;
    logic [3:0]   mode_i = 4'b0000;
    logic         pol_i = 1'b0;
    logic         out_en_i = 1'b1;
    logic         irq_en_i = 1'b0;
    logic         dma_en_i = 1'b0;
    logic         flag_clr_i = 1'b0;
    logic         ref_o, pin_o, flag_o, irq_o, dma_o;

    always #2 clk = ~clk;

    oc_channel #(.CNT_W(W)) u_oc_channel (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .update_i(update_i),
        .ccr_wr_i(ccr_wr_i), .ccr_wdata_i(ccr_wdata_i), .preload_en_i(preload_en_i),
        .dir_sel_i(dir_sel_i), .mode_i(mode_i), .pol_i(pol_i), .out_en_i(out_en_i),
        .irq_en_i(irq_en_i), .dma_en_i(dma_en_i), .flag_clr_i(flag_clr_i),
        .ref_o(ref_o), .pin_o(pin_o), .flag_o(flag_o), .irq_o(irq_o), .dma_o(dma_o)
    );

    // behavioural reference model
    int  m_pre, m_sh;
    bit  m_eq_prev, m_ref, m_flag, m_dma;
    bit  t_eq, t_evt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_sh = 0; m_eq_prev = 0; m_ref = 0; m_flag = 0; m_dma = 0;
        end else begin
            t_eq  = (int'(cnt_i) == m_sh);
            t_evt = (dir_sel_i == 2'b00) && t_eq && !m_eq_prev;
            if (dir_sel_i == 2'b00) begin
                case (mode_i)
                    4'd1: if (t_evt) m_ref = 1;
                    4'd2: if (t_evt) m_ref = 0;
                    4'd3: if (t_evt) m_ref = !m_ref;
                    4'd4: m_ref = 0;
                    4'd5: m_ref = 1;
                    default: ;
                endcase
            end
            if (t_evt) m_flag = 1;
            else if (flag_clr_i) m_flag = 0;
            m_dma = t_evt && dma_en_i;
            m_eq_prev = t_eq;
            if (!preload_en_i && ccr_wr_i) m_sh = int'(ccr_wdata_i);
            else if (preload_en_i && update_i) m_sh = m_pre;
            if (ccr_wr_i) m_pre = int'(ccr_wdata_i);
        end
    end

    int    n_cmp = 0;
    int    n_bad = 0;
    string req = "R10";
    bit    done = 0;

    task automatic chk(string name, bit act, bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        chk("ref_o",  ref_o,  m_ref);
        chk("pin_o",  pin_o,  out_en_i ? (m_ref ^ pol_i) : 1'b0);
        chk("flag_o", flag_o, m_flag);
        chk("irq_o",  irq_o,  m_flag && irq_en_i);
        chk("dma_o",  dma_o,  m_dma);
    endtask

    task automatic write_ccr(int v);
        ccr_wr_i = 1; ccr_wdata_i = W'(v);
        cyc();
        ccr_wr_i = 0;
    endtask

    task automatic sweep(int lo, int hi);
        for (int c = lo; c <= hi; c++) begin
            cnt_i = W'(c);
            cyc();
        end
    endtask

    initial begin
        req = "R10"; // reset state
        cyc(); cyc();
        rst_n = 1;
        cyc();

        // R1 R2: immediate write, set-on-match
        req = "R2";
        write_ccr(5);
        mode_i = 4'd1;
        sweep(0, 9);
        // R3: clear flag, then clear coinciding with match
        req = "R3";
        flag_clr_i = 1; cyc(); flag_clr_i = 0; cyc();
        cnt_i = 0; cyc();
        flag_clr_i = 1; cnt_i = 5; cyc(); flag_clr_i = 0; cyc();
        flag_clr_i = 1; cyc(); flag_clr_i = 0;

        // R6: clear-on-match and toggle, with polarity changes (R10)
        req = "R6";
        mode_i = 4'd2; sweep(0, 7);
        mode_i = 4'd3; irq_en_i = 1; dma_en_i = 1;
        for (int k = 0; k < 4; k++) begin
            pol_i = k[0];
            sweep(0, 7);
        end
        flag_clr_i = 1; cyc(); flag_clr_i = 0;

        // R7 R8: forcing while compare keeps running
        req = "R8";
        mode_i = 4'd5; sweep(0, 7);
        flag_clr_i = 1; cyc(); flag_clr_i = 0;
        mode_i = 4'd4; sweep(0, 7);
        req = "R7";
        mode_i = 4'd5; cyc(); mode_i = 4'd4; cyc(); mode_i = 4'd5; cyc();

        // R4: requests disabled, match still sets the flag
        req = "R4";
        irq_en_i = 0; dma_en_i = 0; flag_clr_i = 1; cyc(); flag_clr_i = 0;
        mode_i = 4'd3; sweep(0, 7);
        irq_en_i = 1; cyc();

        // R1: preload path
        req = "R1";
        flag_clr_i = 1; cyc(); flag_clr_i = 0;
        preload_en_i = 1;
        write_ccr(9);
        sweep(0, 12);
        update_i = 1; cnt_i = 0; cyc(); update_i = 0;
        sweep(1, 12);

        // R5: frozen and unused codes
        req = "R5";
        mode_i = 4'd0; sweep(0, 12);
        mode_i = 4'd7; sweep(0, 12);
        mode_i = 4'd15; sweep(0, 12);

        // R9: non-output direction
        req = "R9";
        flag_clr_i = 1; cyc(); flag_clr_i = 0;
        dir_sel_i = 2'b01; mode_i = 4'd4; sweep(0, 12);
        dir_sel_i = 2'b10; mode_i = 4'd3; sweep(0, 12);

        // R10: output disable and polarity
        req = "R10";
        dir_sel_i = 2'b00; mode_i = 4'd5; out_en_i = 0; pol_i = 0; cyc(); cyc();
        pol_i = 1; cyc(); out_en_i = 1; cyc(); pol_i = 0; cyc();
        mode_i = 4'd4; cyc(); pol_i = 1; cyc();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule